// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing protocol engine of a 4096 x 8 serial EEPROM model. It watches an oversampled two-wire bus (SCL and SDA brought in as plain inputs), resolves start and stop conditions and clock edges in the system clock domain, and answers as a slave. The slave only ever pulls SDA low, through an active-low output enable. The master selects the device with one byte: a fixed four-bit prefix, three bits compared against strap inputs, and a direction bit. A write selection is followed by two word-address bytes and then the data bytes.

Accepted data bytes are passed one at a time, each with its target address, to an external page-write controller. A stop condition then asks that controller to program them. While the controller reports busy, the engine refuses its own select byte, so a host can poll until programming ends. Reads fetch bytes through a synchronous memory read port. A read can start from the current pointer, from an address set by a dummy write followed by a repeated start, or go on byte after byte. A write-protect input, latched at the close of the address phase, blocks programming.

Top module: `eeprom_bus_slave`

## Requirements
- R1: After reset the engine holds sda_oe low, issues no pw_load or pw_commit, and its address pointer is 0.
- R2: A select byte is acknowledged only if bits 7..4 are 1010, bits 3..1 equal strap[2:0], and pw_busy is low. Bit 0 chooses the direction: 1 for read, 0 for write. A refused select leaves SDA released until the next START.
- R3: Each acknowledge holds SDA low through the high phase of the ninth clock of the byte. sda_oe only rises while SCL is low.
- R4: After a write select, two address bytes follow, high byte first. The pointer becomes {high[3:0], low[7:0]}, and high bits 7..4 are ignored.
- R5: Each acknowledged data byte is presented on pw_load with pw_addr and pw_data. The five low pointer bits then advance and wrap inside the 32-byte page, while the upper bits stay fixed.
- R6: A STOP after at least one accepted data byte gives one pw_commit pulse. A STOP with no accepted data gives none.
- R7: While pw_busy is high a matching select byte is not acknowledged. Polling with a write select sees an ACK only once programming ends.
- R8: wp_in is latched when the acknowledge of the second address byte ends. If it is 1, the first data byte gets no ACK and nothing is loaded or committed. Reads ignore wp_in.
- R9: Read data goes out MSB first. A master ACK (SDA low in the ninth clock) gets the next byte; a master NACK makes the engine release SDA and wait for STOP.
- R10: Each byte read or written leaves the pointer at that byte's address plus one, with page wrap for writes. A read without an address phase starts at the pointer.
- R11: Consecutive read bytes step through the full 12-bit address and wrap from 4095 to 0.
- R12: A dummy write carrying an address, then a repeated START and a read select, reads from that address.
- R13: A START at any bit position abandons the current transfer and restarts select-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level, asynchronous |
| sda_in | input | 1 | Resolved bus data level, asynchronous |
| strap | input | 3 | Device-select strap bits compared with select bits 3..1 |
| wp_in | input | 1 | Write protect, 1 blocks programming |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_raddr | output | 12 | Memory read address (the pointer) |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_raddr |
| pw_load | output | 1 | One-cycle strobe: accepted data byte |
| pw_addr | output | 12 | Target address of the loaded byte |
| pw_data | output | 8 | Loaded data byte |
| pw_commit | output | 1 | One-cycle strobe: program the loaded bytes |
| pw_busy | input | 1 | Page-write controller is programming |

## Verification
The bench builds the engine with its default parameters: a 12-bit address, 32-byte pages and two synchronizer stages. With those defaults, the page wrap on writes (offsets 30, 31, 0, 1) and the 4095 to 0 wrap on reads can both be hit directly with a handful of bytes. The bench's memory model keeps pw_busy high for a few hundred cycles after each commit, which is long enough that the first polling select always meets a busy device and later ones do not.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == SEL_PREFIX) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/esl_bus_sampler.sv
module esl_bus_sampler
    import eeprom_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_s, sda_s, scl_d, sda_d;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

    // Start and stop need a steady high clock, so neither coincides with a clock edge
    AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.start, ev.stop, ev.rise, ev.fall})); // R13

endmodule

// File: rtl/esl_addr_ptr.sv
module esl_addr_ptr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_full,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load_en) begin
            ptr <= load_val;
        end else if (inc_full) begin
            ptr <= ptr + ADDR_W'(1);
        end else if (inc_page) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + PAGE_W'(1))};
        end
    end

    AST_PAGE_STEP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
        ($past(inc_page) && !$past(load_en) && !$past(inc_full))
        |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R5

endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
    import eeprom_slave_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    input  logic              wp_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              pw_load,
    output logic [ADDR_W-1:0] pw_addr,
    output logic [7:0]        pw_data,
    output logic              pw_commit,
    input  logic              pw_busy
);
    localparam int HI_W = ADDR_W - 8;

    bus_ev_t     ev;
    eng_state_e  state;
    logic [3:0]  bitcnt;
    logic        in_ack;
    logic        rd_sel;
    logic        wp_lat;
    logic        pending;
    logic        master_ack;
    logic [7:0]  rx;
    logic [7:0]  tx;
    logic [HI_W-1:0]   addr_hi;
    logic              ptr_ld, ptr_inc_full, ptr_inc_page;
    logic [ADDR_W-1:0] ptr_val, ptr;
    logic              scl_lvl, stop_seen;

    esl_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    esl_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst(rst), .load_en(ptr_ld), .load_val(ptr_val),
        .inc_full(ptr_inc_full), .inc_page(ptr_inc_page), .ptr(ptr)
    );

    assign mem_raddr = ptr;
    assign scl_lvl   = ev.scl;
    assign stop_seen = ev.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            bitcnt       <= '0;
            in_ack       <= 1'b0;
            rd_sel       <= 1'b0;
            wp_lat       <= 1'b0;
            pending      <= 1'b0;
            master_ack   <= 1'b0;
            rx           <= '0;
            tx           <= '0;
            addr_hi      <= '0;
            sda_oe       <= 1'b0;
            pw_load      <= 1'b0;
            pw_addr      <= '0;
            pw_data      <= '0;
            pw_commit    <= 1'b0;
            ptr_ld       <= 1'b0;
            ptr_val      <= '0;
            ptr_inc_full <= 1'b0;
            ptr_inc_page <= 1'b0;
        end else begin
            pw_load      <= 1'b0;
            pw_commit    <= 1'b0;
            ptr_ld       <= 1'b0;
            ptr_inc_full <= 1'b0;
            ptr_inc_page <= 1'b0;
            if (ev.start) begin
                state   <= ST_DEVSEL;
                bitcnt  <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
            end else if (ev.stop) begin
                state     <= ST_IDLE;
                bitcnt    <= '0;
                in_ack    <= 1'b0;
                sda_oe    <= 1'b0;
                pw_commit <= pending;
                pending   <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                        if (ev.rise && !in_ack && bitcnt < 4'd8) begin
                            rx     <= {rx[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && !in_ack && bitcnt == 4'd8) begin
                            // byte complete: decide ACK at start of ninth clock
                            in_ack <= 1'b1;
                            if (state == ST_DEVSEL) begin
                                if (sel_match(rx, strap) && !pw_busy) begin
                                    sda_oe <= 1'b1;
                                    rd_sel <= rx[0];
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_ADDR_HI) begin
                                sda_oe  <= 1'b1;
                                addr_hi <= rx[HI_W-1:0];
                            end else if (state == ST_ADDR_LO) begin
                                sda_oe  <= 1'b1;
                                ptr_ld  <= 1'b1;
                                ptr_val <= {addr_hi, rx};
                            end else if (wp_lat) begin
                                state <= ST_WAIT;
                            end else begin
                                sda_oe       <= 1'b1;
                                pw_load      <= 1'b1;
                                pw_addr      <= ptr;
                                pw_data      <= rx;
                                ptr_inc_page <= 1'b1;
                                pending      <= 1'b1;
                            end
                        end else if (ev.fall && in_ack) begin
                            // end of ninth clock: release and move on
                            sda_oe <= 1'b0;
                            in_ack <= 1'b0;
                            bitcnt <= '0;
                            if (state == ST_DEVSEL) begin
                                if (rd_sel) begin
                                    state        <= ST_RDATA;
                                    tx           <= {mem_rdata[6:0], 1'b0};
                                    sda_oe       <= ~mem_rdata[7];
                                    bitcnt       <= 4'd1;
                                    ptr_inc_full <= 1'b1;
                                end else begin
                                    state <= ST_ADDR_HI;
                                end
                            end else if (state == ST_ADDR_HI) begin
                                state <= ST_ADDR_LO;
                            end else if (state == ST_ADDR_LO) begin
                                state  <= ST_WDATA;
                                wp_lat <= wp_in;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (bitcnt < 4'd8) begin
                                sda_oe <= ~tx[7];
                                tx     <= {tx[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            master_ack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (master_ack) begin
                                state        <= ST_RDATA;
                                tx           <= {mem_rdata[6:0], 1'b0};
                                sda_oe       <= ~mem_rdata[7];
                                bitcnt       <= 4'd1;
                                ptr_inc_full <= 1'b1;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_RISES_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_lvl)); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe); // R1
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        pw_commit |-> $past(stop_seen)); // R6
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        pw_load |-> !pw_busy); // R7
    AST_WP_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
        pw_load |-> !wp_lat); // R8

endmodule

// File: tb/eeprom_bus_slave_tb.sv
module eeprom_bus_slave_tb;
    localparam int AW       = 12;
    localparam int BUSY_CYC = 300;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic wp = 1'b0;
    logic sda_oe;
    logic [AW-1:0] mem_raddr;
    logic [7:0] mem_rdata;
    logic pw_load, pw_commit;
    logic [AW-1:0] pw_addr;
    logic [7:0] pw_data;
    logic pw_busy;
    logic line;
    assign line = sda_m & ~sda_oe;

    eeprom_bus_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(line), .strap(strap), .wp_in(wp),
        .sda_oe(sda_oe), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .pw_load(pw_load), .pw_addr(pw_addr), .pw_data(pw_data),
        .pw_commit(pw_commit), .pw_busy(pw_busy)
    );

    // memory and page-write controller model
    logic [7:0]    mem  [4096];
    logic [7:0]    pbuf [32];
    logic [AW-1:0] padr [32];
    logic          pval [32];
    int            busy_cnt;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 7 + 3);
            for (int i = 0; i < 32; i++) pval[i] <= 1'b0;
            busy_cnt <= 0;
            pw_busy  <= 1'b0;
        end else begin
            mem_rdata <= mem[mem_raddr];
            if (pw_load) begin
                pval[pw_addr[4:0]] <= 1'b1;
                pbuf[pw_addr[4:0]] <= pw_data;
                padr[pw_addr[4:0]] <= pw_addr;
            end
            if (pw_commit) begin
                pw_busy  <= 1'b1;
                busy_cnt <= BUSY_CYC;
            end else if (pw_busy) begin
                if (busy_cnt == 1) begin
                    pw_busy <= 1'b0;
                    for (int i = 0; i < 32; i++) begin
                        if (pval[i]) mem[padr[i]] <= pbuf[i];
                        pval[i] <= 1'b0;
                    end
                end
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    logic [7:0] refm [4096];
    logic [7:0] wdat [64];
    logic [7:0] rdat [64];
    logic [AW-1:0] refptr;
    int nchk = 0;
    int nerr = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        scl = 1'b0; wt(4); sda_m = b; wt(4); scl = 1'b1; wt(8);
    endtask

    task automatic bit_in(output logic v);
        scl = 1'b0; wt(4); sda_m = 1'b1; wt(4); scl = 1'b1; wt(4); v = line; wt(4);
    endtask

    task automatic bus_start();
        scl = 1'b0; wt(4); sda_m = 1'b1; wt(4); scl = 1'b1; wt(8); sda_m = 1'b0; wt(8);
    endtask

    task automatic bus_stop();
        scl = 1'b0; wt(4); sda_m = 1'b0; wt(4); scl = 1'b1; wt(8); sda_m = 1'b1; wt(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(v);
        ack = ~v;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        logic v;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_in(v);
            b = {b[6:0], v};
        end
        bit_out(~mack);
    endtask

    function automatic logic [AW-1:0] pg(input logic [AW-1:0] a, input int k);
        return {a[AW-1:5], 5'(int'(a[4:0]) + k)};
    endfunction

    function automatic logic [7:0] sel(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    // write transaction; acks[0]=select, [1]=hi, [2]=lo, [3+k]=data k
    task automatic do_write(input logic [AW-1:0] a, input logic [3:0] junk, input int n,
                            output logic [39:0] acks);
        logic ak;
        acks = '0;
        bus_start();
        send_byte(sel(strap, 1'b0), ak); acks[0] = ak;
        if (ak) begin
            send_byte({junk, a[11:8]}, ak); acks[1] = ak;
            send_byte(a[7:0], ak); acks[2] = ak;
            for (int k = 0; k < n && ak; k++) begin
                send_byte(wdat[k], ak);
                acks[3+k] = ak;
            end
        end
        bus_stop();
        if (!wp && n > 0) begin
            for (int k = 0; k < n; k++) refm[pg(a, k)] = wdat[k];
            refptr = pg(a, n);
        end else if (!wp) begin
            refptr = a;
        end
    endtask

    task automatic poll(output int tries);
        logic ak;
        tries = 0;
        do begin
            tries++;
            bus_start();
            send_byte(sel(strap, 1'b0), ak);
            bus_stop();
        end while (!ak && tries < 40);
    endtask

    task automatic read_tail(input int n, output logic ak);
        bus_start();
        send_byte(sel(strap, 1'b1), ak);
        if (ak) for (int k = 0; k < n; k++) recv_byte(rdat[k], k != n - 1);
        bus_stop();
    endtask

    task automatic do_rand_read(input logic [AW-1:0] a, input int n, output logic ak);
        logic a1, a2, a3;
        bus_start();
        send_byte(sel(strap, 1'b0), a1);
        send_byte({4'h0, a[11:8]}, a2);
        send_byte(a[7:0], a3);
        read_tail(n, ak);
        ak = ak & a1 & a2 & a3;
        refptr = a + AW'(n);
    endtask

    task automatic do_cur_read(input int n, output logic ak);
        read_tail(n, ak);
        refptr = refptr + AW'(n);
    endtask

    initial begin
        logic [39:0] acks;
        logic ak;
        int tries;
        logic [AW-1:0] a, e;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) refm[i] = 8'(i * 7 + 3);
        refptr = '0;
        wt(5);
        rst = 1'b0;
        wt(3);
        chk(sda_oe == 1'b0 && pw_load == 1'b0 && pw_commit == 1'b0, "R1 reset outputs",
            {29'd0, sda_oe, pw_load, pw_commit}, 32'd0);
        wt(20);

        // R10 R1: pointer starts at 0
        do_cur_read(1, ak);
        chk(ak && rdat[0] == refm[0], "R1 R10 first current read at 0", rdat[0], refm[0]);

        // R4 R5 R6: byte write with junk high nibble
        wdat[0] = 8'hA5;
        do_write(12'h123, 4'hF, 1, acks);
        chk(acks[3:0] == 4'hF, "R3 R4 write acks", acks[3:0], 4'hF);
        poll(tries);
        chk(tries > 1, "R7 first poll refused while busy", tries, 2);
        do_rand_read(12'h123, 1, ak);
        chk(ak && rdat[0] == 8'hA5, "R4 R12 random read after write", rdat[0], 8'hA5);
        do_cur_read(1, ak);
        chk(ak && rdat[0] == refm[12'h124], "R10 current address read", rdat[0], refm[12'h124]);

        // R5: page wrap
        for (int k = 0; k < 4; k++) wdat[k] = 8'hC0 + 8'(k);
        do_write(12'h03E, 4'h0, 4, acks);
        chk(acks[6:0] == 7'h7F, "R5 page write acks", acks[6:0], 7'h7F);
        poll(tries);
        do_rand_read(12'h03E, 2, ak);
        chk(rdat[0] == 8'hC0 && rdat[1] == 8'hC1, "R5 bytes at 3E 3F", {rdat[0], rdat[1]}, 16'hC0C1);
        do_rand_read(12'h020, 3, ak);
        chk(rdat[0] == 8'hC2 && rdat[1] == 8'hC3, "R5 wrapped bytes at 20 21", {rdat[0], rdat[1]}, 16'hC2C3);
        chk(rdat[2] == refm[12'h022], "R9 sequential third byte", rdat[2], refm[12'h022]);
        chk(refm[12'h040] == 8'(12'h040 * 7 + 3), "R5 next page untouched (model)", refm[12'h040], 8'(12'h040 * 7 + 3));

        // R11: full wrap on reads
        do_rand_read(12'hFFE, 4, ak);
        for (int k = 0; k < 4; k++) begin
            e = 12'hFFE + AW'(k);
            chk(rdat[k] == refm[e], "R11 sequential wrap", rdat[k], refm[e]);
        end
        do_cur_read(1, ak);
        chk(rdat[0] == refm[12'h002], "R10 R11 pointer after wrap", rdat[0], refm[12'h002]);

        // R8: write protect
        wp = 1'b1;
        wdat[0] = 8'h5A;
        do_write(12'h200, 4'h0, 1, acks);
        chk(acks[3:0] == 4'h7, "R8 first data byte refused", acks[3:0], 4'h7);
        poll(tries);
        chk(tries == 1, "R8 R6 no commit under protect", tries, 1);
        do_rand_read(12'h200, 1, ak);
        chk(ak && rdat[0] == refm[12'h200], "R8 read under protect, data unchanged", rdat[0], refm[12'h200]);
        wp = 1'b0;

        // R6: STOP without data gives no commit
        do_write(12'h300, 4'h0, 0, acks);
        poll(tries);
        chk(tries == 1, "R6 no commit without data", tries, 1);

        // R2: select mismatches
        bus_start(); send_byte(sel(3'b011, 1'b0), ak); bus_stop();
        chk(!ak, "R2 strap mismatch refused", ak, 0);
        bus_start(); send_byte({4'b1011, strap, 1'b1}, ak); bus_stop();
        chk(!ak && sda_oe == 1'b0, "R2 prefix mismatch refused", ak, 0);

        // R13: START mid-byte aborts
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        do_rand_read(12'h123, 1, ak);
        chk(ak && rdat[0] == 8'hA5, "R13 restart after abort", rdat[0], 8'hA5);

        // R9: NACK ends read, SDA released
        do_rand_read(12'h050, 1, ak);
        chk(sda_oe == 1'b0, "R9 released after master NACK", sda_oe, 0);

        // random writes and reads
        for (int it = 0; it < 16; it++) begin
            a = AW'($urandom % 4096);
            n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
            do_write(a, 4'($urandom), n, acks);
            chk(acks[0] && acks[2 + n], "R5 random write acked", acks[7:0], 8'hFF);
            poll(tries);
            do_rand_read(a, n, ak);
            for (int k = 0; k < n; k++) begin
                e = a + AW'(k);
                chk(rdat[k] == refm[e], "R11 R12 random readback", rdat[k], refm[e]);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule